// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block counts cycles of a dedicated slow clock and, when software fails to restart it in time, either raises an interrupt, requests a system reset, or raises the interrupt first and requests the reset on the next expiry. The expiry period comes from a four-bit period code. A single control register holds the mode, the period code and the interrupt flag. A separate status register holds a sticky flag that records that the watchdog has requested a reset.

Two changes are guarded against runaway software: turning reset off and changing the period code. Both take effect only through a timed unlock. Writing ones to the unlock bit and the reset-enable bit together opens a four-cycle window. The next control write inside that window may load any mode and period, including all zeros to stop the watchdog. While the sticky flag is set, reset enable stays forced on until software clears the flag.

The unlock logic is a two-state machine. WIN_LOCKED goes to WIN_OPEN on an unlock write. WIN_OPEN goes back to WIN_LOCKED when a control write consumes the window or when four cycles have run out. The operating mode is decoded from the two enable bits into MODE_OFF, MODE_IRQ, MODE_RST and MODE_IRQ_RST. On expiry, MODE_IRQ sets the flag. MODE_RST pulses the reset request and sets the sticky flag. MODE_IRQ_RST sets the flag and clears interrupt enable, which moves the block to MODE_RST.

Top module: `wdt_core`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, and `irq` and `sys_rst_req` are low.
- R2: A control write with bit 4 (unlock) and bit 3 (reset enable) both one opens the window and sets reset enable. Bit 4 then reads one for exactly the four cycles after that write and clears by itself if no control write follows.
- R3: The period code (bits 5,2,1,0 as code[3],code[2:0]) changes, and bit 3 can be cleared, only by a control write made while the window is open; such a write closes the window. Outside the window those fields are ignored, except that writing one to bit 3 always sets reset enable. Bit 6 is written by every control write.
- R4: With code n, the watchdog expires after 2^(BASE_LOG2+n) consecutive enabled cycles without a kick. Codes above MAX_CODE act as MAX_CODE but read back as written.
- R5: A kick sampled at a clock edge zeroes the count, and a kick in the last cycle of the period prevents that expiry.
- R6: With bit 6 set and bit 3 clear, expiry sets the flag at bit 7 without a reset request. `irq` follows the flag. Writing one to bit 7 clears the flag, and expiry wins over a clear in the same cycle.
- R7: With bit 6 clear and bit 3 set, expiry drives `sys_rst_req` high for exactly the next cycle and sets status bit 0.
- R8: With bits 6 and 3 both set, the first expiry sets the flag and clears bit 6 with no reset request. The following expiry then requests the reset.
- R9: While status bit 0 is set, control bit 3 reads one and a window write cannot clear it. Writing status bit 0 as zero clears the sticky flag; writing it as one has no effect.
- R10: With bits 6 and 3 both clear the counter is held at zero and no flag or reset event occurs.
- R11: The count restarts from zero after every expiry. If the period is shortened below the current count, expiry happens on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rsel | input | 1 | Read target: 0 control, 1 status |
| reg_rdata | output | 8 | Read data of the selected register |
| kick | input | 1 | Restart the count |
| irq | output | 1 | Interrupt, equal to the flag bit |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench attacks the window edges. A design whose window is one cycle too short or too long shows the unlock bit at the wrong edge. A design that lets a write outside the window change the period or drop reset enable leaves the wrong value in the control register. A kick in the final count cycle, a code above the maximum, and a period shortened below the running count each separate off-by-one and unclamped counters from correct ones. The bench also checks the escalating mode and the sticky-flag lock: a design that resets on the first expiry, or that lets a window write clear reset enable while the sticky flag is set, produces a reset pulse or a bit-3 value the reference model does not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W         = 8;
    localparam int PRE_W         = 4;
    localparam int WINDOW_CYCLES = 4;

    // control register bit positions
    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_PRE3 = 5;
    localparam int B_UNLK = 4;
    localparam int B_RE   = 3;
    // status register bit position
    localparam int B_STICKY = 0;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_IRQ,
        MODE_RST,
        MODE_IRQ_RST
    } wdt_mode_e;

    typedef enum logic {
        WIN_LOCKED,
        WIN_OPEN
    } win_state_e;

endpackage

// File: rtl/wdt_window_fsm.sv
module wdt_window_fsm
    import wdt_pkg::*;
#(
    parameter int WINDOW = WINDOW_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic unlock_pat,
    output logic win_open,
    output logic wr_accept
);

    localparam int LW = $clog2(WINDOW + 1);

    win_state_e       state_q, state_d;
    logic [LW-1:0]    left_q, left_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_LOCKED;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            WIN_LOCKED: begin
                if (ctrl_wr && unlock_pat) begin
                    state_d = WIN_OPEN;
                    left_d  = LW'(WINDOW);
                end
            end
            WIN_OPEN: begin
                if (ctrl_wr || left_q == LW'(1)) begin
                    state_d = WIN_LOCKED;
                    left_d  = '0;
                end else begin
                    left_d  = left_q - LW'(1);
                end
            end
        endcase
    end

    always_comb begin
        win_open  = (state_q == WIN_OPEN);
        wr_accept = win_open && ctrl_wr;
    end

    a_r2_opens_only_on_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(ctrl_wr && unlock_pat));

    a_r2_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LW'(WINDOW));

    a_r3_write_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && ctrl_wr) |=> !win_open);

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             kick,
    input  logic [PRE_W-1:0] code,
    output logic             expired
);

    localparam int CW = BASE_LOG2 + MAX_CODE;

    logic [CW-1:0]    cnt_q;
    logic [PRE_W-1:0] eff_code;
    logic [CW:0]      span;
    logic [CW-1:0]    last;

    always_comb begin
        eff_code = (code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : code;
        span     = (CW+1)'(1) << (BASE_LOG2 + int'(eff_code));
        last     = CW'(span - (CW+1)'(1));
        expired  = active && !kick && (cnt_q >= last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || kick || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    a_r5_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));

    a_r11_restart_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> (cnt_q == '0));

    a_r10_idle_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (cnt_q == '0));

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_accept,
    input  logic             win_open,
    input  logic             expired,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [REG_W-1:0] stat_rd,
    output logic [PRE_W-1:0] code,
    output logic             active,
    output logic             irq,
    output logic             sys_rst_req
);

    logic             flag_q, ie_q, rst_en_q, sticky_q, rreq_q;
    logic [PRE_W-1:0] pre_q;
    wdt_mode_e        mode;
    logic             set_flag, drop_ie, set_sticky;

    always_comb begin
        if (rst_en_q || sticky_q) begin
            mode = ie_q ? MODE_IRQ_RST : MODE_RST;
        end else begin
            mode = ie_q ? MODE_IRQ : MODE_OFF;
        end
    end

    // expiry actions per mode
    always_comb begin
        set_flag   = 1'b0;
        drop_ie    = 1'b0;
        set_sticky = 1'b0;
        unique case (mode)
            MODE_OFF: ;
            MODE_IRQ: set_flag = expired;
            MODE_RST: set_sticky = expired;
            MODE_IRQ_RST: begin
                set_flag = expired;
                drop_ie  = expired;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            ie_q     <= 1'b0;
            rst_en_q <= 1'b0;
            sticky_q <= 1'b0;
            rreq_q   <= 1'b0;
            pre_q    <= '0;
        end else begin
            rreq_q <= set_sticky;

            if (set_flag) begin
                flag_q <= 1'b1;
            end else if (ctrl_wr && wr_data[B_FLAG]) begin
                flag_q <= 1'b0;
            end

            if (drop_ie) begin
                ie_q <= 1'b0;
            end else if (ctrl_wr) begin
                ie_q <= wr_data[B_IE];
            end

            if (set_sticky) begin
                rst_en_q <= 1'b1;
            end else if (wr_accept) begin
                rst_en_q <= wr_data[B_RE] | sticky_q;
            end else if (ctrl_wr && wr_data[B_RE]) begin
                rst_en_q <= 1'b1;
            end

            if (wr_accept) begin
                pre_q <= {wr_data[B_PRE3], wr_data[2:0]};
            end

            if (set_sticky) begin
                sticky_q <= 1'b1;
            end else if (stat_wr && !wr_data[B_STICKY]) begin
                sticky_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_rd     = {flag_q, ie_q, pre_q[3], win_open,
                       rst_en_q | sticky_q, pre_q[2:0]};
        stat_rd     = {{(REG_W-1){1'b0}}, sticky_q};
        code        = pre_q;
        active      = (mode != MODE_OFF);
        irq         = flag_q;
        sys_rst_req = rreq_q;
    end

    a_r9_sticky_holds_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_q |-> rst_en_q);

    a_r6_irq_mode_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IRQ && expired) |=> (flag_q && !sys_rst_req));

    a_r8_first_expiry_escalates: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IRQ_RST && expired) |=> (flag_q && !ie_q && !sys_rst_req));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    a_r7_pulse_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> sticky_q);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rsel,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             kick,
    output logic             irq,
    output logic             sys_rst_req
);

    logic             ctrl_wr, stat_wr, unlock_pat;
    logic             win_open, wr_accept, expired, active;
    logic [PRE_W-1:0] code;
    logic [REG_W-1:0] ctrl_rd, stat_rd;

    always_comb begin
        ctrl_wr    = reg_wr && !reg_sel;
        stat_wr    = reg_wr && reg_sel;
        unlock_pat = reg_wdata[B_UNLK] && reg_wdata[B_RE];
        reg_rdata  = reg_rsel ? stat_rd : ctrl_rd;
    end

    wdt_window_fsm #(.WINDOW(WINDOW_CYCLES)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .unlock_pat (unlock_pat),
        .win_open   (win_open),
        .wr_accept  (wr_accept)
    );

    wdt_timebase #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .kick    (kick),
        .code    (code),
        .expired (expired)
    );

    wdt_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .stat_wr     (stat_wr),
        .wr_data     (reg_wdata),
        .wr_accept   (wr_accept),
        .win_open    (win_open),
        .expired     (expired),
        .ctrl_rd     (ctrl_rd),
        .stat_rd     (stat_rd),
        .code        (code),
        .active      (active),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> !sys_rst_req);

endmodule

// File: tb/wdt_core_bench.sv
module wdt_core_bench;

    localparam int CLK_PERIOD      = 10;
    localparam int BL2             = 2;
    localparam int MAXC            = 9;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_rsel = 1'b0;
    logic       kick = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sys_rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_core #(.BASE_LOG2(BL2), .MAX_CODE(MAXC)) u_wdt_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rsel    (reg_rsel),
        .reg_rdata   (reg_rdata),
        .kick        (kick),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_flag = 0, m_ie = 0, m_re = 0, m_pre = 0, m_sticky = 0, m_rreq = 0, m_cnt = 0, m_win = 0;

    always @(posedge clk) begin
        int  code, last, fl, ie, re, pre, st, win;
        bit  act, to, wc, ws;
        if (!rst_n) begin
            m_flag = 0; m_ie = 0; m_re = 0; m_pre = 0;
            m_sticky = 0; m_rreq = 0; m_cnt = 0; m_win = 0;
        end else begin
            wc   = reg_wr && !reg_sel;
            ws   = reg_wr && reg_sel;
            code = (m_pre > MAXC) ? MAXC : m_pre;
            last = (1 << (BL2 + code)) - 1;
            act  = (m_ie != 0) || (m_re != 0) || (m_sticky != 0);
            to   = act && !kick && (m_cnt >= last);
            fl = m_flag; ie = m_ie; re = m_re; pre = m_pre; st = m_sticky; win = m_win;
            if (wc) begin
                if (reg_wdata[7]) fl = 0;
                ie = int'(reg_wdata[6]);
                if (m_win > 0) begin
                    re  = (reg_wdata[3] || m_sticky != 0) ? 1 : 0;
                    pre = int'(reg_wdata[5]) * 8 + int'(reg_wdata[2:0]);
                end else if (reg_wdata[3]) begin
                    re = 1;
                end
            end
            if (ws && !reg_wdata[0]) st = 0;
            if (m_win > 0) win = wc ? 0 : m_win - 1;
            else if (wc && reg_wdata[4] && reg_wdata[3]) win = 4;
            m_rreq = 0;
            if (to && m_ie != 0) begin
                fl = 1;
                if (m_re != 0 || m_sticky != 0) ie = 0;
            end
            if (to && m_ie == 0) begin
                st = 1; re = 1; m_rreq = 1;
            end
            m_cnt = (!act || kick || to) ? 0 : m_cnt + 1;
            m_flag = fl; m_ie = ie; m_re = re; m_pre = pre; m_sticky = st; m_win = win;
        end
    end

    function automatic int exp_ctrl();
        return (m_flag << 7) | (m_ie << 6) | (((m_pre >> 3) & 1) << 5) |
               ((m_win > 0 ? 1 : 0) << 4) | (((m_re | m_sticky) != 0 ? 1 : 0) << 3) |
               (m_pre & 7);
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", int'(reg_rdata), reg_rsel ? m_sticky : exp_ctrl(), "model read");
            check("R6", int'(irq), m_flag, "model irq");
            check("R7", int'(sys_rst_req), m_rreq, "model reset request");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG_CYCLES && !done) begin
            errors++;
            done = 1'b1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input bit sel, input int data);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = 8'(data);
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic at_neg();
        @(negedge clk); #1;
    endtask

    task automatic rd(input bit sel, output int v);
        reg_rsel = sel; #1;
        v = int'(reg_rdata);
        reg_rsel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int v;
        edges(3); #1 rst_n = 1'b1;

        // R1 reset state
        at_neg();
        rd(0, v); check("R1", v, 8'h00, "control after reset");
        rd(1, v); check("R1", v, 8'h00, "status after reset");
        check("R1", int'(irq), 0, "irq after reset");
        check("R1", int'(sys_rst_req), 0, "reset request after reset");

        // R10 idle, nothing happens
        edges(50); at_neg();
        check("R10", int'(irq), 0, "irq while off");

        // R3 period and reset fields ignored outside window
        wr(0, 8'h27); at_neg();
        rd(0, v); check("R3", v, 8'h00, "locked write ignored");

        // R6 interrupt-only mode, code 0 period 4
        wr(0, 8'h40);
        edges(3); at_neg();
        check("R6", int'(irq), 0, "irq before period end");
        edges(1); at_neg();
        check("R6", int'(irq), 1, "irq at period end");
        check("R6", int'(sys_rst_req), 0, "no reset in irq mode");

        // R6 clear flag, R5 kick holds count
        kick = 1'b1;
        wr(0, 8'hC0); at_neg();
        rd(0, v); check("R6", v, 8'h40, "flag cleared by write one");
        edges(20); at_neg();
        check("R5", int'(irq), 0, "kick held prevents expiry");

        // R5 kick in final cycle
        @(posedge clk); #1 kick = 1'b0;
        edges(3); #1 kick = 1'b1;
        @(posedge clk); #1 kick = 1'b0;
        at_neg();
        check("R5", int'(irq), 0, "kick in last cycle");
        kick = 1'b1;

        // R2 window length
        wr(0, 8'h18); at_neg();
        rd(0, v); check("R2", v, 8'h18, "unlock sets bits 4 and 3");
        edges(3); at_neg();
        rd(0, v); check("R2", v, 8'h18, "window open in fourth cycle");
        edges(1); at_neg();
        rd(0, v); check("R2", v, 8'h08, "window closed after four cycles");

        // R3 clearing reset enable outside window ignored
        wr(0, 8'h40); at_neg();
        rd(0, v); check("R3", v, 8'h48, "reset enable kept outside window");

        // R3 in-window write, R4 code 1 period 8
        wr(0, 8'h18);
        wr(0, 8'h41); at_neg();
        rd(0, v); check("R3", v, 8'h41, "window write applied and consumed");
        @(posedge clk); #1 kick = 1'b0;
        edges(7); at_neg();
        check("R4", int'(irq), 0, "code 1 before 8 cycles");
        edges(1); at_neg();
        check("R4", int'(irq), 1, "code 1 at 8 cycles");

        // R4 reserved code clamps to max
        kick = 1'b1;
        wr(0, 8'hC0);
        wr(0, 8'h18);
        wr(0, 8'h67); at_neg();
        rd(0, v); check("R4", v, 8'h67, "reserved code reads back raw");
        @(posedge clk); #1 kick = 1'b0;
        edges(2047); at_neg();
        check("R4", int'(irq), 0, "clamped period not yet over");
        edges(1); at_neg();
        check("R4", int'(irq), 1, "clamped period 2048");

        // R11 shortening below running count, then restart
        edges(100);
        wr(0, 8'h18);
        wr(0, 8'hC0); at_neg();
        rd(0, v); check("R11", v, 8'h40, "shortened period applied");
        check("R11", int'(irq), 0, "flag cleared by window write");
        edges(1); at_neg();
        check("R11", int'(irq), 1, "expiry next cycle after shortening");
        wr(0, 8'hC0); at_neg();
        check("R11", int'(irq), 0, "flag cleared");
        edges(1); at_neg();
        check("R11", int'(irq), 0, "restarted count not yet over");
        edges(1); at_neg();
        check("R11", int'(irq), 1, "restarted period of 4");

        // R7 reset-only mode
        kick = 1'b1;
        wr(0, 8'h18);
        wr(0, 8'h88); at_neg();
        rd(0, v); check("R7", v, 8'h08, "reset-only configured");
        @(posedge clk); #1 kick = 1'b0;
        edges(3); at_neg();
        check("R7", int'(sys_rst_req), 0, "no request before period end");
        edges(1); at_neg();
        check("R7", int'(sys_rst_req), 1, "request after expiry");
        rd(1, v); check("R7", v, 8'h01, "sticky flag set");
        edges(1); at_neg();
        check("R7", int'(sys_rst_req), 0, "request lasts one cycle");
        kick = 1'b1;

        // R9 sticky flag locks reset enable
        wr(0, 8'h18);
        wr(0, 8'h00); at_neg();
        rd(0, v); check("R9", v, 8'h08, "reset enable held by sticky flag");
        wr(1, 8'h01); at_neg();
        rd(1, v); check("R9", v, 8'h01, "writing one keeps sticky");
        wr(1, 8'h00); at_neg();
        rd(1, v); check("R9", v, 8'h00, "writing zero clears sticky");

        // R10 turn off through window
        wr(0, 8'h18);
        wr(0, 8'h00); at_neg();
        rd(0, v); check("R10", v, 8'h00, "watchdog off");
        kick = 1'b0;
        edges(100); at_neg();
        check("R10", int'(irq), 0, "no irq while off");
        check("R10", int'(sys_rst_req), 0, "no request while off");
        rd(1, v); check("R10", v, 8'h00, "no sticky while off");

        // R8 escalating mode
        kick = 1'b1;
        wr(0, 8'h18);
        wr(0, 8'h48); at_neg();
        rd(0, v); check("R8", v, 8'h48, "both enables set");
        @(posedge clk); #1 kick = 1'b0;
        edges(3); at_neg();
        check("R8", int'(irq), 0, "before first expiry");
        edges(1); at_neg();
        check("R8", int'(irq), 1, "first expiry raises irq");
        check("R8", int'(sys_rst_req), 0, "first expiry no reset");
        rd(0, v); check("R8", v, 8'h88, "interrupt enable dropped");
        edges(3); at_neg();
        check("R8", int'(sys_rst_req), 0, "before second expiry");
        edges(1); at_neg();
        check("R8", int'(sys_rst_req), 1, "second expiry resets");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule